// File: doc/BRIEF.md
# Redundant-Thread Slack Fetch Controller

This controller decides, cycle by cycle, which of two redundant copies of one program may use the shared fetch slot, which takes up to eight instructions. The leading copy runs ahead. The trailing copy may fetch only after the leading copy has fetched more than a programmed number of instructions beyond it. Because of this gap, the leading copy's cache misses and branch resolutions come before the trailing copy needs them. For each grant the requesting thread reports how many instructions it actually fetched. From these counts an internal lag counter follows the distance between the two copies.

The leading copy writes its resolved branches into a small in-order queue: one direction bit and one target address per branch. When the trailing fetch unit reaches a branch, it takes the oldest entry at the queue head instead of asking a predictor. The trailing copy is stalled while the queue is empty at one of its branches. The leading copy is stalled while the queue is full. The slack value comes from an input that is sampled only during reset.

Top module: `sf_slack_fetch`

## Requirements
- R1: While reset is held and just after it is released, `lag_count` is 0, `bq_empty` is 1 and `bq_full` is 0.
- R2: `gnt_trail` is 1 in a cycle exactly when `trail_req` is 1, `lag_count` is strictly greater than the captured slack, and not (`trail_br` = 1 with `bq_empty` = 1).
- R3: `gnt_lead` is 1 exactly when `lead_req` is 1, `bq_full` is 0 and `gnt_trail` is 0; the two grants are never both 1.
- R4: On each clock edge `lag_count` increases by min(`lead_cnt`, 8) when `gnt_lead` is 1, or decreases by min(`trail_cnt`, 8) when `gnt_trail` is 1. The result saturates at 0 and at 2^LAG_W-1 (1023 by default).
- R5: Branch outcomes leave the queue in the order they entered. `bq_head_taken` and `bq_head_target` show the oldest entry whenever `bq_empty` is 0.
- R6: When `trail_br` is 1 while the queue is empty, `gnt_trail` is 0 whatever the lag.
- R7: With BQ_DEPTH entries held, `bq_full` is 1 and `gnt_lead` is 0. A `br_push` in that state is dropped and never appears at the head.
- R8: The slack is taken from `slack_init` only while `rst_n` is 0. Changes to `slack_init` after reset have no effect on grants.
- R9: An entry is removed from the queue only on a clock edge where `gnt_trail` and `trail_br` are both 1. A push is accepted on any edge where `br_push` is 1 and `bq_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; slack is loaded while low |
| slack_init | input | LAG_W | Slack value captured during reset |
| lead_req | input | 1 | Leading thread asks for the fetch slot |
| lead_cnt | input | CNT_W | Instructions the leading thread fetched in a granted cycle |
| trail_req | input | 1 | Trailing thread asks for the fetch slot |
| trail_cnt | input | CNT_W | Instructions the trailing thread fetched in a granted cycle |
| trail_br | input | 1 | The trailing fetch group holds a branch and needs an outcome |
| br_push | input | 1 | Leading thread resolved a branch this cycle |
| br_taken | input | 1 | Direction of the resolved branch (1 = taken) |
| br_target | input | 32 | Target address of the resolved branch |
| gnt_lead | output | 1 | Fetch slot granted to the leading thread |
| gnt_trail | output | 1 | Fetch slot granted to the trailing thread |
| bq_head_taken | output | 1 | Direction at the queue head |
| bq_head_target | output | 32 | Target at the queue head |
| bq_empty | output | 1 | Outcome queue holds no entry |
| bq_full | output | 1 | Outcome queue holds BQ_DEPTH entries |
| lag_count | output | LAG_W | Instructions the leading thread is ahead |

## Verification
The assertions assume that `slack_init` does not change in the cycle when reset is released, and that the count inputs matter only in cycles where the matching grant is high. The bench changes `slack_init` only while reset is held or at negative edges well after release. During the constrained-random phase it draws counts of 0 to 15 to exercise the clamp at eight, and it mixes branch pushes and trailing branches at rates that keep the queue moving between empty and full. Directed runs cover a full queue with dropped pushes, saturation of the lag counter at its top value, and a slack of zero.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int SF_ADDR_W = 32;

  typedef struct packed {
    logic                 taken;
    logic [SF_ADDR_W-1:0] target;
  } bq_entry_t;

  // reported fetch count limited to the fetch width
  function automatic int unsigned clamp_count(int unsigned c, int unsigned fw);
    return (c > fw) ? fw : c;
  endfunction

  // next lag value, saturating at both ends
  function automatic int unsigned lag_step(int unsigned lag, int unsigned add,
                                           int unsigned sub, int unsigned maxv);
    int unsigned s;
    s = lag + add;
    if (s > maxv) s = maxv;
    if (sub > s) return 0;
    return s - sub;
  endfunction
endpackage

// File: rtl/sf_lag_tracker.sv
module sf_lag_tracker #(
  parameter int FETCH_W = 8,
  parameter int LAG_W   = 10,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_cnt,
  input  logic             sub_en,
  input  logic [CNT_W-1:0] sub_cnt,
  output logic [LAG_W-1:0] lag
);
  import sf_pkg::*;
  localparam int unsigned LAG_MAX = (1 << LAG_W) - 1;

  logic [LAG_W-1:0] lag_q, lag_d;
  int unsigned      add_v, sub_v;

  always_comb begin
    add_v = add_en ? clamp_count(32'(add_cnt), FETCH_W) : 0;
    sub_v = sub_en ? clamp_count(32'(sub_cnt), FETCH_W) : 0;
    lag_d = LAG_W'(lag_step(32'(lag_q), add_v, sub_v, LAG_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lag_q <= '0;
    else        lag_q <= lag_d;
  end

  assign lag = lag_q;
endmodule

// File: rtl/sf_branch_queue.sv
module sf_branch_queue #(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  sf_pkg::bq_entry_t push_data,
  input  logic              pop,
  output sf_pkg::bq_entry_t head,
  output logic              empty,
  output logic              full
);
  import sf_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  bq_entry_t        store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (occ == '0);
  assign full    = (occ == OCC_W'(DEPTH));
  assign head    = store[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/sf_fetch_arbiter.sv
module sf_fetch_arbiter #(
  parameter int LAG_W = 10
) (
  input  logic             lead_req,
  input  logic             trail_req,
  input  logic             trail_br,
  input  logic [LAG_W-1:0] lag,
  input  logic [LAG_W-1:0] slack,
  input  logic             q_empty,
  input  logic             q_full,
  output logic             lag_open,
  output logic             gnt_lead,
  output logic             gnt_trail
);
  logic trail_ok;

  assign lag_open  = (lag > slack);
  assign trail_ok  = trail_req && lag_open && !(trail_br && q_empty);
  assign gnt_trail = trail_ok;
  assign gnt_lead  = lead_req && !q_full && !trail_ok;
endmodule

// File: rtl/sf_slack_fetch.sv
module sf_slack_fetch #(
  parameter  int FETCH_W  = 8,
  parameter  int LAG_W    = 10,
  parameter  int BQ_DEPTH = 8,
  localparam int CNT_W    = $clog2(FETCH_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAG_W-1:0] slack_init,
  input  logic             lead_req,
  input  logic [CNT_W-1:0] lead_cnt,
  input  logic             trail_req,
  input  logic [CNT_W-1:0] trail_cnt,
  input  logic             trail_br,
  input  logic             br_push,
  input  logic             br_taken,
  input  logic [31:0]      br_target,
  output logic             gnt_lead,
  output logic             gnt_trail,
  output logic             bq_head_taken,
  output logic [31:0]      bq_head_target,
  output logic             bq_empty,
  output logic             bq_full,
  output logic [LAG_W-1:0] lag_count
);
  import sf_pkg::*;

  logic [LAG_W-1:0] slack_q;
  logic             lag_open;
  logic             bq_pop;
  bq_entry_t        in_entry, head_entry;

  // slack follows the input only while reset is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slack_q <= slack_init;
    else        slack_q <= slack_q;
  end

  assign in_entry = '{taken: br_taken, target: br_target};
  assign bq_pop   = gnt_trail && trail_br;

  sf_fetch_arbiter #(.LAG_W(LAG_W)) u_arb (
    .lead_req (lead_req),
    .trail_req(trail_req),
    .trail_br (trail_br),
    .lag      (lag_count),
    .slack    (slack_q),
    .q_empty  (bq_empty),
    .q_full   (bq_full),
    .lag_open (lag_open),
    .gnt_lead (gnt_lead),
    .gnt_trail(gnt_trail)
  );

  sf_lag_tracker #(.FETCH_W(FETCH_W), .LAG_W(LAG_W), .CNT_W(CNT_W)) u_lag (
    .clk    (clk),
    .rst_n  (rst_n),
    .add_en (gnt_lead),
    .add_cnt(lead_cnt),
    .sub_en (gnt_trail),
    .sub_cnt(trail_cnt),
    .lag    (lag_count)
  );

  sf_branch_queue #(.DEPTH(BQ_DEPTH)) u_bq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (br_push),
    .push_data(in_entry),
    .pop      (bq_pop),
    .head     (head_entry),
    .empty    (bq_empty),
    .full     (bq_full)
  );

  assign bq_head_taken  = head_entry.taken;
  assign bq_head_target = head_entry.target;
endmodule

// File: rtl/sf_slack_fetch_chk.sv
module sf_slack_fetch_chk #(
  parameter int LAG_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gnt_lead,
  input logic             gnt_trail,
  input logic             trail_br,
  input logic             bq_empty,
  input logic             bq_full,
  input logic             bq_pop,
  input logic             lag_open,
  input logic [LAG_W-1:0] slack_q,
  input logic [LAG_W-1:0] lag_count
);
  // R3: one owner of the fetch slot per cycle
  a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_lead, gnt_trail}));

  // R2: trailing grant needs the lag above the slack
  a_r2_trail_lag: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_trail |-> lag_open);

  // R6: no outcome available means no trailing fetch at a branch
  a_r6_empty_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_br && bq_empty) |-> !gnt_trail);

  // R7: a full queue blocks the leading thread and stays full without a pop
  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    bq_full |-> !gnt_lead);
  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bq_full && !bq_pop) |=> bq_full);

  // R4: a leading grant never lowers the lag, a trailing grant never raises it
  a_r4_lead_up: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_lead |=> (lag_count >= $past(lag_count)));
  a_r4_trail_down: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_trail |=> (lag_count <= $past(lag_count)));

  // R8: captured slack does not move out of reset
  a_r8_slack_held: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(slack_q));

  // R1: the queue cannot be empty and full at once
  a_r1_empty_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(bq_empty && bq_full));
endmodule

bind sf_slack_fetch sf_slack_fetch_chk #(.LAG_W(LAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gnt_lead (gnt_lead),
  .gnt_trail(gnt_trail),
  .trail_br (trail_br),
  .bq_empty (bq_empty),
  .bq_full  (bq_full),
  .bq_pop   (bq_pop),
  .lag_open (lag_open),
  .slack_q  (slack_q),
  .lag_count(lag_count)
);

// File: tb/sf_slack_fetch_test.sv
module sf_slack_fetch_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW    = 8;
  localparam int LW    = 10;
  localparam int DEPTH = 8;
  localparam int CW    = 4;
  localparam int LMAX  = 1023;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [LW-1:0] slack_init = 0;
  logic          lead_req = 0, trail_req = 0, trail_br = 0;
  logic [CW-1:0] lead_cnt = 0, trail_cnt = 0;
  logic          br_push = 0, br_taken = 0;
  logic [31:0]   br_target = 0;
  logic          gnt_lead, gnt_trail, bq_head_taken, bq_empty, bq_full;
  logic [31:0]   bq_head_target;
  logic [LW-1:0] lag_count;

  int n_tests = 0, n_fail = 0;
  int m_lag, m_slack;
  logic [32:0] m_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sf_slack_fetch #(.FETCH_W(FW), .LAG_W(LW), .BQ_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .slack_init(slack_init),
    .lead_req(lead_req), .lead_cnt(lead_cnt),
    .trail_req(trail_req), .trail_cnt(trail_cnt), .trail_br(trail_br),
    .br_push(br_push), .br_taken(br_taken), .br_target(br_target),
    .gnt_lead(gnt_lead), .gnt_trail(gnt_trail),
    .bq_head_taken(bq_head_taken), .bq_head_target(bq_head_target),
    .bq_empty(bq_empty), .bq_full(bq_full), .lag_count(lag_count));

  function automatic int fclamp(int c);
    return (c > FW) ? FW : c;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(int s);
    @(negedge clk);
    rst_n = 0; slack_init = LW'(s);
    lead_req = 0; trail_req = 0; trail_br = 0; br_push = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_lag = 0; m_slack = s; m_q.delete();
    #1;
    chk(lag_count == 0, "R1 lag", lag_count, 0);
    chk(bq_empty == 1, "R1 empty", bq_empty, 1);
    chk(bq_full == 0, "R1 full", bq_full, 0);
  endtask

  task automatic step(bit lr, int lc, bit tr, int tc, bit tb,
                      bit bp, bit bt, logic [31:0] ba, int slk);
    bit e_tr, e_ld, e_pop;
    @(negedge clk);
    lead_req = lr; lead_cnt = CW'(lc); trail_req = tr; trail_cnt = CW'(tc);
    trail_br = tb; br_push = bp; br_taken = bt; br_target = ba;
    slack_init = LW'(slk);
    #1;
    chk(lag_count == LW'(m_lag), "R4 lag", lag_count, m_lag);
    chk(bq_empty == (m_q.size() == 0), "R9 empty", bq_empty, m_q.size() == 0);
    chk(bq_full == (m_q.size() == DEPTH), "R7 full", bq_full, m_q.size() == DEPTH);
    if (m_q.size() > 0)
      chk({bq_head_taken, bq_head_target} == m_q[0], "R5 head",
          {bq_head_taken, bq_head_target}, m_q[0]);
    e_tr = tr && (m_lag > m_slack) && !(tb && m_q.size() == 0);
    e_ld = lr && (m_q.size() != DEPTH) && !e_tr;
    if (tr && tb && m_q.size() == 0)
      chk(gnt_trail == 0, "R6 stall", gnt_trail, 0);
    else
      chk(gnt_trail == e_tr, "R2 gnt_trail", gnt_trail, e_tr);
    chk(gnt_lead == e_ld, "R3 gnt_lead", gnt_lead, e_ld);
    @(posedge clk);
    e_pop = e_tr && tb;
    if (e_ld) m_lag = m_lag + fclamp(lc);
    if (m_lag > LMAX) m_lag = LMAX;
    if (e_tr) m_lag = (fclamp(tc) > m_lag) ? 0 : m_lag - fclamp(tc);
    if (bp && m_q.size() < DEPTH) begin
      if (e_pop) void'(m_q.pop_front());
      m_q.push_back({bt, ba});
    end else if (e_pop) void'(m_q.pop_front());
  endtask

  task automatic random_phase(int cycles);
    for (int i = 0; i < cycles; i++)
      step($urandom_range(0, 9) < 8, $urandom_range(0, 15),
           $urandom_range(0, 9) < 7, $urandom_range(0, 15),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           1'($urandom), $urandom, $urandom_range(0, LMAX));
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    do_reset(5);
    // R8: slack_init changed after reset; model keeps 5
    for (int i = 0; i < 2; i++) step(1, 2, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 3, 0, 0, 0, 0, 0);   // lag 4 <= 5: R8 trail refused
    step(1, 2, 0, 0, 0, 0, 0, 0, 0);   // lag 6
    step(0, 0, 1, 3, 0, 0, 0, 0, 0);   // lag 6 > 5: trail granted
    // R6: trailing branch with empty queue
    step(1, 8, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 0, 0, 0, 0);
    // R7: fill queue, then pushes while full are dropped
    for (int i = 0; i < DEPTH + 3; i++)
      step(0, 0, 0, 0, 0, 1, 1'(i), 32'h1000 + i, 0);
    step(1, 4, 0, 0, 0, 0, 0, 0, 0);   // R7 lead blocked
    // R5: drain in order through trailing branches
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, 0, 1, 0, 0, 0, 0);
    random_phase(3000);
    // R4: saturation at the top of the lag counter
    do_reset(3);
    for (int i = 0; i < 135; i++) step(1, 15, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(lag_count == LW'(LMAX), "R4 saturate", lag_count, LMAX);
    // R4: lower saturation with slack of zero
    do_reset(0);
    step(1, 2, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 9, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(lag_count == 0, "R4 floor", lag_count, 0);
    random_phase(3000);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule